// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a synchronous memory with a 32-bit word split into four 8-bit lanes and a small, parameterized depth. Every address, control and write-data input is captured in an input register on the rising clock edge. A second edge performs the access, and read data leaves through an output register, so a read has a two-edge pipeline. An access is opened by either of two equivalent address strobes. Further beats of the same burst are stepped by an advance input through a two-bit wrapping counter. The counter runs in one of two orders, additive or exclusive-or, chosen by a mode input.

A write covers either the whole word, through a global write input that overrides the lane selects, or only the lanes that are selected while the lane-write enable is high. Three chip selects of mixed polarity are sampled with the strobe, and a strobe that finds any of them inactive puts the block in the deselected state. The output path has a valid flag and forces the data to zero whenever it is not driven. Output enable gates the flag combinationally. The flag is also held low for the first output cycle of a read that follows a deselected state.

Read data has no ready input. The memory cannot stall, so a consumer must take `rdata` in every cycle in which `rvalid` is high. A value stays on the output until the next access or deselect replaces it.

Top module: `sync_burst_sram`

## Requirements
- R1: Inputs are registered on the rising edge, and a read's data and valid flag appear after the second rising edge that follows the edge sampling its address.
- R2: With `wr_all` high during a beat, all four lanes are written, whatever `wr_lanes_en` and `lane_sel` hold.
- R3: With `wr_all` low and `wr_lanes_en` high, lane i (data bits 8i+7 down to 8i) is written only when `lane_sel[i]` is 1, and the other lanes keep their contents.
- R4: A beat with `wr_all` low and either `wr_lanes_en` low or `lane_sel` all zero is a read and changes no stored data.
- R5: A strobe is selected only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination deselects the block: no access happens, and the output is undriven from the next edge on.
- R6: `rvalid` is low whenever `oe` is low, with no clock edge needed, and `rdata` is zero whenever `rvalid` is low.
- R7: The first read beat after a deselected state (reset counts as deselected) shows `rvalid` low in its first output cycle. The same data becomes valid in the next cycle if no access replaces it.
- R8: `strobe_cpu` and `strobe_ctl` each open an access at `addr`, and both behave alike.
- R9: While a burst is open, a cycle with `adv` high and no strobe performs the next beat, and the two-bit beat counter wraps from 3 to 0. A cycle with no strobe and no effective advance performs no access and leaves the output unchanged.
- R10: Beat k of a burst that starts at low address bits s uses low bits (s+k) mod 4 when `burst_linear`=1 at the strobe, and s xor k when it is 0. The upper address bits stay fixed.
- R11: A write beat makes the output undriven from the following edge until a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address sampled with a strobe |
| strobe_cpu | input | 1 | Address strobe, first source |
| strobe_ctl | input | 1 | Address strobe, second source |
| adv | input | 1 | Step the open burst to its next beat |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_linear | input | 1 | 1: additive beat order, 0: exclusive-or order |
| wr_all | input | 1 | Write every lane of the beat |
| wr_lanes_en | input | 1 | Enable writes to the selected lanes |
| lane_sel | input | LANES | Per-lane write select |
| wdata | input | 8*LANES | Write data |
| oe | input | 1 | Output enable, combinational |
| rdata | output | 8*LANES | Read data, zero when not valid |
| rvalid | output | 1 | Read data is driven |

## Verification
The hardest case to reach from the ports is the masked first output cycle of a read that leaves the deselected state. Reaching it takes a strobe with a wrong chip select, then possibly stray advance cycles, then a selected read, with the output sampled at exactly the cycle its data arrives and again one cycle later. The bench walks that sequence once for each of the three chip selects held wrong, with an advance pulse placed inside the deselected stretch. It also sweeps every address, every lane mask, and every start offset in both burst orders against a word model kept inside the bench.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_ADD = 1'b1
  } burst_order_e;

  // low address bits of beat k for a burst that started at s
  function automatic logic [1:0] beat_low(input logic [1:0] s, input logic [1:0] k,
                                          input burst_order_e o);
    return (o == ORD_ADD) ? 2'(s + k) : (s ^ k);
  endfunction
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              close,
  input  logic [ADDR_W-1:0] addr_in,
  input  burst_order_e      order_in,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              open_q
);
  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        k_q, k_n;
  burst_order_e      ord_q, ord_n;
  logic              open_n;

  always_comb begin
    base_n = base_q;
    k_n    = k_q;
    ord_n  = ord_q;
    open_n = open_q;
    if (load) begin
      base_n = addr_in;
      k_n    = 2'd0;
      ord_n  = order_in;
      open_n = 1'b1;
    end else if (close) begin
      open_n = 1'b0;
    end else if (step && open_q) begin
      k_n = k_q + 2'd1;
    end
  end

  assign acc_addr = {base_n[ADDR_W-1:2], beat_low(base_n[1:0], k_n, ord_n)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      k_q    <= 2'd0;
      ord_q  <= ORD_XOR;
      open_q <= 1'b0;
    end else begin
      base_q <= base_n;
      k_q    <= k_n;
      ord_q  <= ord_n;
      open_q <= open_n;
    end
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   lane_we,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] out_q
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (lane_we[l]) mem[addr] <= wdata[l*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (rd_en) q <= mem[addr];
    end

    assign out_q[l*8 +: 8] = q;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               strobe_cpu,
  input  logic               strobe_ctl,
  input  logic               adv,
  input  logic               sel_a_n,
  input  logic               sel_b,
  input  logic               sel_c_n,
  input  logic               burst_linear,
  input  logic               wr_all,
  input  logic               wr_lanes_en,
  input  logic [LANES-1:0]   lane_sel,
  input  logic [8*LANES-1:0] wdata,
  input  logic               oe,
  output logic [8*LANES-1:0] rdata,
  output logic               rvalid
);
  localparam int DATA_W = 8 * LANES;

  // input register stage
  logic [ADDR_W-1:0] r_addr;
  logic              r_sp, r_sc, r_adv, r_sa_n, r_sb, r_sc_n, r_all, r_len;
  logic [LANES-1:0]  r_lane;
  logic [DATA_W-1:0] r_wdata;
  burst_order_e      r_order;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_addr  <= '0;
      r_sp    <= 1'b0;
      r_sc    <= 1'b0;
      r_adv   <= 1'b0;
      r_sa_n  <= 1'b1;
      r_sb    <= 1'b0;
      r_sc_n  <= 1'b1;
      r_all   <= 1'b0;
      r_len   <= 1'b0;
      r_lane  <= '0;
      r_wdata <= '0;
      r_order <= ORD_XOR;
    end else begin
      r_addr  <= addr;
      r_sp    <= strobe_cpu;
      r_sc    <= strobe_ctl;
      r_adv   <= adv;
      r_sa_n  <= sel_a_n;
      r_sb    <= sel_b;
      r_sc_n  <= sel_c_n;
      r_all   <= wr_all;
      r_len   <= wr_lanes_en;
      r_lane  <= lane_sel;
      r_wdata <= wdata;
      r_order <= burst_linear ? ORD_ADD : ORD_XOR;
    end
  end

  // access decode
  logic start, chosen, sel_start, desel_start, adv_beat, beat, write_req;
  logic wr_access, rd_access, open_q;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] out_q;

  assign start       = r_sp | r_sc;
  assign chosen      = !r_sa_n && r_sb && !r_sc_n;
  assign sel_start   = start && chosen;
  assign desel_start = start && !chosen;
  assign adv_beat    = r_adv && !start && open_q;
  assign beat        = sel_start || adv_beat;
  assign write_req   = r_all || (r_len && (|r_lane));
  assign wr_access   = beat && write_req;
  assign rd_access   = beat && !write_req;
  assign lane_we     = !wr_access ? '0 : (r_all ? '1 : r_lane);

  sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sel_start),
    .step     (r_adv && !start),
    .close    (desel_start),
    .addr_in  (r_addr),
    .order_in (r_order),
    .acc_addr (acc_addr),
    .open_q   (open_q)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_we (lane_we),
    .rd_en   (rd_access),
    .addr    (acc_addr),
    .wdata   (r_wdata),
    .out_q   (out_q)
  );

  // output drive control
  logic drive_q, mask_q, desel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      mask_q  <= 1'b0;
      desel_q <= 1'b1;
    end else if (desel_start) begin
      drive_q <= 1'b0;
      mask_q  <= 1'b0;
      desel_q <= 1'b1;
    end else if (wr_access) begin
      drive_q <= 1'b0;
      mask_q  <= 1'b0;
      desel_q <= 1'b0;
    end else if (rd_access) begin
      drive_q <= 1'b1;
      mask_q  <= desel_q;
      desel_q <= 1'b0;
    end else begin
      mask_q  <= 1'b0;
    end
  end

  assign rvalid = oe && drive_q && !mask_q;
  assign rdata  = rvalid ? out_q : '0;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               oe,
  input logic               rvalid,
  input logic [8*LANES-1:0] rdata,
  input logic               desel_start,
  input logic               rd_access,
  input logic               wr_access,
  input logic               desel_q,
  input logic               adv_beat,
  input logic [1:0]         k,
  input logic [8*LANES-1:0] out_q
);
  p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rvalid);

  p_quiet_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));

  p_desel_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    desel_start |=> !rvalid);

  p_first_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_access && desel_q) |=> !rvalid);

  p_read_shows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_access && !desel_q) |=> (rvalid == oe));

  p_write_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_access |=> !rvalid);

  p_step_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adv_beat |=> (k == 2'($past(k) + 2'd1)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_access || wr_access) |=> $stable(out_q));
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .oe          (oe),
  .rvalid      (rvalid),
  .rdata       (rdata),
  .desel_start (desel_start),
  .rd_access   (rd_access),
  .wr_access   (wr_access),
  .desel_q     (desel_q),
  .adv_beat    (adv_beat),
  .k           (u_seq.k_q),
  .out_q       (out_q)
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic strobe_cpu = 0, strobe_ctl = 0, adv = 0, sel_a_n = 0, sel_b = 1, sel_c_n = 0;
  logic burst_linear = 0, wr_all = 0, wr_lanes_en = 0, oe = 1;
  logic [3:0] lane_sel = '0;
  logic [31:0] wdata = '0, rdata;
  logic rvalid;

  sync_burst_sram #(.ADDR_W(AW), .LANES(4)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model, built from the requirements
  logic [31:0] m_mem [NW];
  bit m_drive = 0, m_mask = 0, m_desel = 1, m_open = 0, m_lin = 0;
  int m_base = 0, m_k = 0;
  logic [31:0] m_out = '0;

  // two-slot expectation pipe
  bit p0_chk = 0, p0_v = 0, p1_chk = 0, p1_v = 0;
  logic [31:0] p0_d = '0, p1_d = '0;
  string p0_tag = "", p1_tag = "";

  function automatic logic [31:0] pat(input int a);
    logic [7:0] b = 8'(a);
    return {b, ~b, b ^ 8'h5A, b + 8'd3};
  endfunction

  function automatic int order_low(input int s, input int k, input bit lin);
    return lin ? ((s + k) & 3) : (s ^ k);
  endfunction

  task automatic check(input string tag, input bit ok, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual={v,d}=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit cpu, input bit ctl, input bit a_v, input logic [2:0] sel,
                       input bit gw, input bit bwe, input logic [3:0] lane, input int a,
                       input logic [31:0] d, input bit lin, input string tag);
    bit st, ok, wr;
    logic [3:0] lw;
    int acc;
    @(negedge clk);
    if (p1_chk) begin
      if (p1_v) check(p1_tag, rvalid === 1'b1 && rdata === p1_d, {rvalid, rdata}, {1'b1, p1_d});
      else      check(p1_tag, rvalid === 1'b0 && rdata === 32'd0, {rvalid, rdata}, 33'd0);
    end
    p1_chk = p0_chk; p1_v = p0_v; p1_d = p0_d; p1_tag = p0_tag;
    strobe_cpu = cpu; strobe_ctl = ctl; adv = a_v;
    {sel_a_n, sel_b, sel_c_n} = sel;
    wr_all = gw; wr_lanes_en = bwe; lane_sel = lane; addr = AW'(a); wdata = d; burst_linear = lin;
    st = cpu || ctl;
    ok = (sel == 3'b010);
    acc = -1;
    if (st && !ok) begin
      m_open = 0; m_desel = 1; m_drive = 0; m_mask = 0;
    end else if (st) begin
      m_base = a; m_k = 0; m_lin = lin; m_open = 1;
      acc = a;
    end else if (a_v && m_open) begin
      m_k = (m_k + 1) & 3;
      acc = (m_base & ~3) | order_low(m_base & 3, m_k, m_lin);
    end
    if (acc >= 0) begin
      lw = gw ? 4'hF : (bwe ? lane : 4'h0);
      wr = (lw != 0);
      if (wr) begin
        for (int l = 0; l < 4; l++)
          if (lw[l]) m_mem[acc][l*8 +: 8] = d[l*8 +: 8];
        m_drive = 0; m_mask = 0; m_desel = 0;
      end else begin
        m_out = m_mem[acc]; m_drive = 1; m_mask = m_desel; m_desel = 0;
      end
    end else if (!(st && !ok)) begin
      m_mask = 0;
    end
    p0_chk = 1; p0_v = m_drive && !m_mask; p0_d = m_out; p0_tag = tag;
  endtask

  task automatic idle(input string tag);
    issue(0, 0, 0, 3'b010, 0, 0, 4'h0, 0, 32'd0, 0, tag);
  endtask

  task automatic rd(input bit cpu, input int a, input string tag);
    issue(cpu, !cpu, 0, 3'b010, 0, 0, 4'h0, a, 32'd0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 reset state", rvalid === 1'b0 && rdata === 32'd0, {rvalid, rdata}, 33'd0);
    rst_n = 1'b1;

    // R2: global write of every word, lane selects varied and ignored
    for (int a = 0; a < NW; a++)
      issue(0, 1, 0, 3'b010, 1, a[0], 4'(a), a, pat(a), 0, "R2 global write");
    // R1 R8: back-to-back reads through both strobes
    for (int a = 0; a < NW; a++) rd(a[0], a, "R1 R8 pipelined read");
    idle("R9 hold"); idle("R9 hold");

    // R3 lane masks on words 0..15; R4 no-write cycles on words 16..31
    for (int m = 0; m < 16; m++)
      issue(0, 1, 0, 3'b010, 0, 1, 4'(m), m, 32'hC3C3C3C3 ^ {4{4'(m), 4'hF}}, 0, "R3 lane write");
    for (int m = 0; m < 16; m++)
      issue(m[0], !m[0], 0, 3'b010, 0, m[1], m[1] ? 4'h0 : 4'(m), 16 + m, 32'hDEADBEEF, 0, "R4 no write");
    for (int a = 0; a < 32; a++) rd(0, a, "R3 R4 readback");

    // R9 R10 bursts in both orders from every start offset
    for (int lin = 0; lin < 2; lin++)
      for (int s = 0; s < 4; s++) begin
        int b = 8 + lin * 4 + s;
        issue(0, 1, 0, 3'b010, 1, 0, 4'h0, b * 4 + s, 32'hB0000000 | (b << 8), lin[0], "R10 burst write");
        for (int k = 1; k < 4; k++)
          issue(0, 0, 1, 3'b010, 1, 0, 4'h0, 0, 32'hB0000000 | (b << 8) | k, 0, "R9 burst write step");
        rd(1, b * 4 + s, "R10 burst read");
        for (int k = 1; k < 4; k++)
          issue(0, 0, 1, 3'b010, 0, 0, 4'h0, 0, 32'd0, 0, "R9 R10 burst read step");
      end
    for (int a = 32; a < NW; a++) rd(1, a, "R10 order readback");
    idle("R9 hold");

    // R5 R7: each chip select wrong, stray advance, then selected read
    for (int w = 0; w < 3; w++) begin
      issue(1, 0, 0, 3'b010 ^ (3'b100 >> w), 0, 0, 4'h0, 7, 32'd0, 0, "R5 deselect");
      issue(0, 0, 1, 3'b010, 0, 0, 4'h0, 0, 32'd0, 0, "R5 R9 advance while deselected");
      idle("R5 quiet");
      rd(w[0], 40 + w, "R7 first read masked");
      idle("R7 data shown next cycle");
      idle("R9 hold");
    end
    idle("R9 hold"); idle("R9 hold");

    // R6: output enable acts without a clock edge
    #1 oe = 1'b0; #1;
    check("R6 oe low", rvalid === 1'b0 && rdata === 32'd0, {rvalid, rdata}, 33'd0);
    oe = 1'b1; #1;
    check("R6 oe high", rvalid === 1'b1 && rdata === m_out, {rvalid, rdata}, {1'b1, m_out});

    // R11: write makes the output undriven
    issue(0, 1, 0, 3'b010, 1, 0, 4'h0, 3, 32'h13579BDF, 0, "R11 write darkens output");
    idle("R11 still dark"); idle("R11 still dark");
    rd(0, 3, "R11 read after write"); idle("R1 hold"); idle("R1 hold");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule